// File: doc/BRIEF.md
# Debug Register Power-Loss Error Responder

This block is the bus-facing front end for a small bank of debug registers whose owning core sits in a switchable power domain, while the front end itself stays in the always-on domain. It answers every APB access in a single access phase and decides whether that access may touch the debug registers or must be turned away with a slave error.

Two conditions turn an access away. The first is that the core domain is off at the moment of the access. The second is a sticky power-loss flag, which is raised whenever the core-powered input is seen low and stays raised after power returns. A debugger that never polled during the outage still gets an error on its next debug access and so learns that register state may have been lost. The status register is the only location that always answers cleanly. It shows the sticky flag and the live power state, and a read of it while the core is powered drops the flag, which makes the debug registers usable again.

Top module: `dbg_pwr_guard`

## Requirements
- R1: After the always-on reset, the sticky flag is 1 and every scratch register holds 0.
- R2: Every access completes in its first access-phase cycle. `pready` is 1 whenever `psel` and `penable` are both high.
- R3: When `coreOn` is 0, an access to any location other than the status register completes with `pslverr` = 1.
- R4: A clock edge that samples `coreOn` = 0 sets the sticky flag at that edge.
- R5: While the sticky flag is 1, an access to any location other than the status register completes with `pslverr` = 1, even when `coreOn` is 1.
- R6: The status register, at byte address 0x00, never returns an error. Its read data carries the sticky flag in bit 0 and the live `coreOn` value in bit 1, and zeros in all other bits.
- R7: A status read completed with `coreOn` = 1 clears the sticky flag. A status read completed with `coreOn` = 0 leaves it at 1, because the set rule wins.
- R8: An access that returns an error gives `prdata` = 0 and changes no register.
- R9: When no error applies, the scratch registers at byte addresses 4·k (k = 1 to NUM_SCRATCH) can be written and read back. Any other address, including one whose low two bits are not zero, reads 0 and ignores writes.
- R10: A write to the status register does not change the sticky flag or the scratch registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rstN | input | 1 | Always-on domain reset, active low, asynchronous |
| coreOn | input | 1 | 1 while the core power domain is up |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB slave error |

## Verification
The hardest case to reach from the ports is a debug access that fails only because of a power loss that has already ended. This happens when the core comes back up with nothing polling the status register in between. The stimulus lowers `coreOn` for a few idle cycles, raises it again, and only then issues scratch reads and writes, which must fail until a status read with power present clears the flag. The random phase mixes short outages, status reads made during an outage and misaligned addresses, so that both the case where the set rule beats the clear rule and the ordinary clean accesses keep recurring.

// File: rtl/dbg_pwr_guard_pkg.sv
package dbg_pwr_guard_pkg;

  // Strobes handed from control to datapath during an access phase.
  typedef struct packed {
    logic access;     // access phase of an APB transfer
    logic errResp;    // this access is answered with an error
    logic statusSel;  // aligned hit on the status register
    logic scratchSel; // aligned hit on a scratch register
    logic wrScratch;  // committed write into a scratch register
  } strobe_t;

  localparam int STATUS_STICKY_BIT = 0;
  localparam int STATUS_POWER_BIT  = 1;

endpackage

// File: rtl/dbg_pwr_ctrl.sv
module dbg_pwr_ctrl
  import dbg_pwr_guard_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_SCRATCH = 4,
  localparam int IDX_W      = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreOn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output strobe_t          strobe,
  output logic [IDX_W-1:0] wordIdx,
  output logic             stickyQ,
  output logic             pready,
  output logic             pslverr
);

  logic accessPhase;
  logic aligned;
  logic statusHit;
  logic scratchHit;
  logic denied;
  logic clearReq;

  assign accessPhase = psel && penable;
  assign aligned     = (paddr[1:0] == 2'b00);
  assign wordIdx     = paddr[ADDR_W-1:2];
  assign statusHit   = aligned && (wordIdx == '0);
  assign scratchHit  = aligned && (wordIdx != '0) &&
                       (int'(wordIdx) <= NUM_SCRATCH);

  // Everything but the status register is guarded by power and the flag.
  assign denied      = !statusHit && (!coreOn || stickyQ);
  assign clearReq    = accessPhase && statusHit && !pwrite;

  // Sticky flag: set on any edge that sees the core off; set beats clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= 1'b1;
    end else if (!coreOn) begin
      stickyQ <= 1'b1;
    end else if (clearReq) begin
      stickyQ <= 1'b0;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.access     = accessPhase;
    strobe.errResp    = accessPhase && denied;
    strobe.statusSel  = accessPhase && statusHit;
    strobe.scratchSel = accessPhase && scratchHit && !denied;
    strobe.wrScratch  = accessPhase && scratchHit && !denied && pwrite;
  end

  assign pready  = 1'b1;
  assign pslverr = strobe.errResp;

  a_r3_off_errors: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !coreOn && (paddr != '0)) |-> pslverr);

  a_r4_low_sets_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !coreOn |=> stickyQ);

  a_r5_sticky_errors: assert property (@(posedge clk) disable iff (!rstN)
    (stickyQ && psel && penable && (paddr != '0)) |-> pslverr);

  a_r6_status_clean: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && (paddr == '0)) |-> !pslverr);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite && (paddr == '0) && coreOn) |=> !stickyQ);

  a_r2_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable) |-> pready);

endmodule

// File: rtl/dbg_pwr_dpath.sv
module dbg_pwr_dpath
  import dbg_pwr_guard_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_SCRATCH = 4,
  localparam int IDX_W      = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] pwdata,
  input  logic             stickyQ,
  input  logic             coreOn,
  output logic [DATA_W-1:0] prdata
);

  logic [NUM_SCRATCH-1:0][DATA_W-1:0] scratchQ;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] scratchWord;

  for (genvar gi = 0; gi < NUM_SCRATCH; gi++) begin : g_scratch
    logic selThis;
    assign selThis = strobe.wrScratch && (int'(wordIdx) == gi + 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        scratchQ[gi] <= '0;
      end else if (selThis) begin
        scratchQ[gi] <= pwdata;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STATUS_STICKY_BIT] = stickyQ;
    statusWord[STATUS_POWER_BIT]  = coreOn;
  end

  always_comb begin
    scratchWord = '0;
    for (int i = 0; i < NUM_SCRATCH; i++) begin
      if (int'(wordIdx) == i + 1) scratchWord = scratchQ[i];
    end
  end

  always_comb begin
    prdata = '0;
    if (strobe.access && !strobe.errResp) begin
      if (strobe.statusSel)       prdata = statusWord;
      else if (strobe.scratchSel) prdata = scratchWord;
    end
  end

  a_r8_zero_on_error: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errResp |-> (prdata == '0));

  a_r8_no_write_on_error: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.errResp && !strobe.wrScratch) |=> $stable(scratchQ));

  a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusSel && !strobe.wrScratch) |=> $stable(scratchQ));

endmodule

// File: rtl/dbg_pwr_guard.sv
module dbg_pwr_guard
  import dbg_pwr_guard_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_SCRATCH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreOn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);

  localparam int IDX_W = ADDR_W - 2;

  strobe_t          strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             stickyQ;

  dbg_pwr_ctrl #(
    .ADDR_W      (ADDR_W),
    .NUM_SCRATCH (NUM_SCRATCH)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .coreOn  (coreOn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strobe  (strobe),
    .wordIdx (wordIdx),
    .stickyQ (stickyQ),
    .pready  (pready),
    .pslverr (pslverr)
  );

  dbg_pwr_dpath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_SCRATCH (NUM_SCRATCH)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wordIdx (wordIdx),
    .pwdata  (pwdata),
    .stickyQ (stickyQ),
    .coreOn  (coreOn),
    .prdata  (prdata)
  );

endmodule

// File: tb/dbg_pwr_guard_tb_top.sv
`timescale 1ns/1ps
module dbg_pwr_guard_tb_top;

  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int NUM_SCRATCH = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              coreOn = 1'b1;
  logic              psel = 1'b0;
  logic              penable = 1'b0;
  logic              pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [DATA_W-1:0] prdata;
  logic              pready;
  logic              pslverr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model
  bit                mSticky;
  logic [DATA_W-1:0] mScratch [NUM_SCRATCH];

  always #10 clk = ~clk; // 50 MHz

  dbg_pwr_guard #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SCRATCH(NUM_SCRATCH)
  ) dut_i (
    .clk(clk), .rstN(rstN), .coreOn(coreOn), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  function automatic bit isStatus(input logic [ADDR_W-1:0] a);
    return a == '0;
  endfunction

  function automatic int scratchIdx(input logic [ADDR_W-1:0] a);
    int w;
    if (a[1:0] != 2'b00) return -1;
    w = int'(a[ADDR_W-1:2]);
    if (w >= 1 && w <= NUM_SCRATCH) return w - 1;
    return -1;
  endfunction

  function automatic bit expErr(input logic [ADDR_W-1:0] a, input bit on);
    return !isStatus(a) && (!on || mSticky);
  endfunction

  function automatic logic [DATA_W-1:0] expData(input logic [ADDR_W-1:0] a, input bit on);
    logic [DATA_W-1:0] d;
    int s;
    d = '0;
    if (expErr(a, on)) return d;
    if (isStatus(a)) begin
      d[0] = mSticky;
      d[1] = on;
      return d;
    end
    s = scratchIdx(a);
    if (s >= 0) d = mScratch[s];
    return d;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Edge bookkeeping for the model: an edge that sees the core off sets the flag.
  task automatic modelEdge();
    if (!coreOn) mSticky = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
    end
  endtask

  task automatic setCore(input bit v);
    coreOn = v;
    idle(1);
  endtask

  task automatic apb(input bit wr, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d, input string req);
    bit eErr;
    logic [DATA_W-1:0] eData;
    int s;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    penable = 1'b1;
    #5;
    eErr  = expErr(a, coreOn);
    eData = wr ? '0 : expData(a, coreOn);
    check(pready == 1'b1, "R2", DATA_W'(pready), 1);
    check(pslverr == eErr, req, DATA_W'(pslverr), DATA_W'(eErr));
    if (!wr || eErr)
      check(prdata == eData, req, prdata, eData);
    @(posedge clk);
    s = scratchIdx(a);
    if (wr && !eErr && s >= 0) mScratch[s] = d;
    if (!wr && isStatus(a) && coreOn) mSticky = 1'b0;
    modelEdge();
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mSticky = 1'b1;
    for (int i = 0; i < NUM_SCRATCH; i++) mScratch[i] = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state visible through status and scratch after clearing
    apb(1'b0, 8'h00, '0, "R1 R6 status after reset");
    apb(1'b0, 8'h04, '0, "R1 scratch reads zero");
    apb(1'b0, 8'h10, '0, "R1 last scratch reads zero");

    // R9: clean write/read
    apb(1'b1, 8'h04, 32'hDEAD_BEEF, "R9 write");
    apb(1'b0, 8'h04, '0, "R9 readback");
    apb(1'b1, 8'h14, 32'h1111_2222, "R9 unmapped write");
    apb(1'b0, 8'h14, '0, "R9 unmapped read zero");
    apb(1'b1, 8'h06, 32'h3333_4444, "R9 misaligned write");
    apb(1'b0, 8'h04, '0, "R9 misaligned did not hit");

    // R10: status write inert
    apb(1'b1, 8'h00, 32'hFFFF_FFFF, "R10 status write");
    apb(1'b0, 8'h00, '0, "R10 sticky still clear");

    // R3, R4, R8: core off
    coreOn = 1'b0;
    apb(1'b0, 8'h04, '0, "R3 R8 read while off");
    apb(1'b1, 8'h04, 32'h0BAD_0BAD, "R3 R8 write while off");
    apb(1'b0, 8'h00, '0, "R4 R6 R7 status while off");
    setCore(1'b1);

    // R5: power back, flag still set
    apb(1'b0, 8'h04, '0, "R5 read after outage");
    apb(1'b1, 8'h08, 32'h5555_AAAA, "R5 R8 write after outage");
    apb(1'b0, 8'h00, '0, "R7 status clears flag");
    apb(1'b0, 8'h04, '0, "R8 data survived error write");
    apb(1'b0, 8'h08, '0, "R8 blocked write left zero");

    // R4: single-cycle dip between accesses
    coreOn = 1'b0; idle(1); coreOn = 1'b1; idle(2);
    apb(1'b0, 8'h04, '0, "R4 single-cycle dip sets flag");
    apb(1'b0, 8'h00, '0, "R7 clear after dip");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [ADDR_W-1:0] a;
      r = int'($urandom_range(0, 99));
      if (r < 6) setCore(!coreOn);
      r = int'($urandom_range(0, 9));
      if (r < 3)       a = 8'h00;
      else if (r < 8)  a = ADDR_W'(4 * int'($urandom_range(1, NUM_SCRATCH)));
      else if (r < 9)  a = ADDR_W'(4 * (NUM_SCRATCH + 1));
      else             a = ADDR_W'($urandom_range(1, 3));
      apb($urandom_range(0, 1) == 1, a, $urandom, "R3 R5 R6 R7 R9 random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule